// File: doc/BRIEF.md
# Page Permission and Reference/Change Checker

This block judges a single 64-bit leaf page table entry against one memory access. It takes an access kind (load, store or instruction fetch) and three context flags: problem state, privileged context and partition-scoped check. It also takes a 3-bit authority-mask permission. From these it works out the read/write/execute permission the access is granted. It reports whether the access faults, and with which cause bits. It also produces the entry as it should look after the access, with reference and change bits applied, and raises a write-back strobe only when that entry really differs from the one supplied.

A translation walker drives `req_i` for one cycle with the leaf entry and the context. One clock edge later `rsp_valid_o` is high for a single cycle and the registered result is on the outputs. The outputs then hold until the next request. Issuing the memory write and raising any interrupt are left to the caller.

A two-state controller sequences the result. ST_IDLE means no fresh result. ST_RESP means the outputs carry the result of the request taken on the previous edge. The transitions are as follows:
- IDLE_TO_RESP fires when `req_i` is high in ST_IDLE.
- RESP_TO_RESP fires on a back-to-back request in ST_RESP.
- RESP_TO_IDLE fires when ST_RESP sees no request.
- IDLE_STAY fires when ST_IDLE sees no request.

Top module: `pgchk_top`

## Requirements
- R1: After reset, `rsp_valid_o`, `perm_o`, `fault_o`, `cause_o`, `wb_o` and `pte_o` are all zero. A request sampled at a rising edge makes `rsp_valid_o` high for exactly the following cycle, with its result on the outputs. Without a new request, the outputs keep their values afterwards.
- R2: `acc_i` encodes 0 as load, 1 as store and 2 as fetch; 3 is treated as a load. The attribute field is entry bits [5:4]. A fetch with that field equal to 2'b10 (non-idempotent I/O) faults with only `cause_o[0]` (guarded) set, and the protection check is skipped.
- R3: The authority field is entry bits [2:0], read on bit 2, write on bit 1 and execute on bit 0. The privilege bit is entry bit 3. In a process-scoped check (`part_i`=0), an entry with the privilege bit set, accessed with `prob_i`=1, is granted no permission.
- R4: Outside the R3 case, if `privctx_i`, the privilege bit or `part_i` is 1, the permission comes from the entry's authority field alone, and `amr_i` has no effect.
- R5: In all remaining cases the permission is the authority field ANDed with `amr_i`, which uses the same read/write/execute bit order as `perm_o`.
- R6: A load needs read, a store needs write and a fetch needs execute. If the needed permission is missing, `fault_o` is 1 and `cause_o[1]` (protection) is set.
- R7: For any access other than a store, the write bit of `perm_o` (bit 1) is 0.
- R8: On an access without a fault, `pte_o` equals the entry with bit 8 (reference) set, and with bit 7 (change) also set when the access is a store. On a faulting access, `pte_o` equals the supplied entry.
- R9: `wb_o` is 1 exactly when the access did not fault and `pte_o` differs from the supplied entry.
- R10: A faulting store sets `cause_o[2]` (store indicator). Every other result leaves that bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle per check |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| pte_i | input | 64 | Leaf page table entry |
| prob_i | input | 1 | Problem-state (user) access |
| privctx_i | input | 1 | Privileged context |
| part_i | input | 1 | Partition-scoped check |
| amr_i | input | 3 | Authority-mask permission {read, write, execute} |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| perm_o | output | 3 | Granted permission {read, write, execute} |
| fault_o | output | 1 | Access faults |
| cause_o | output | 3 | Cause {store, protection, guarded} |
| pte_o | output | 64 | Updated entry |
| wb_o | output | 1 | Write-back of `pte_o` requested |

## Verification
Random entries, access kinds, flags and masks are applied with a fixed seed and compared with a bench model. This mix covers all three permission branches as well as both guarded and protection faults. Directed cases then separate the branches that random data may confuse. A guarded fetch on an executable page shows that the attribute check takes precedence. A privileged entry used in problem state shows the zero-permission branch. A partition-scoped check with an empty mask shows that the mask is ignored in that case. Entries whose reference and change bits are already set, or only half set, show whether the write-back strobe follows a real change and not the mere access.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic store;
        logic prot;
        logic guard;
    } cause_t;

endpackage

// File: rtl/pgchk_auth.sv
module pgchk_auth
    import pgchk_pkg::*;
#(
    parameter logic [1:0] ATT_NIIO = 2'b10
) (
    input  acc_e       acc,
    input  logic [1:0] att,
    input  logic       priv,
    input  perm_t      eaa,
    input  logic       prob,
    input  logic       privctx,
    input  logic       part,
    input  perm_t      amr,
    output perm_t      grant,
    output logic       fault,
    output cause_t     cause
);

    perm_t raw;
    perm_t need;
    logic  is_store;
    logic  guarded;
    logic  missing;

    assign is_store = (acc == ACC_STORE);
    assign guarded  = (acc == ACC_FETCH) && (att == ATT_NIIO);

    // three-way authority selection
    always_comb begin
        if (!part && priv && prob) begin
            raw = '0;
        end else if (privctx || priv || part) begin
            raw = eaa;
        end else begin
            raw = eaa & amr;
        end
    end

    // permission each access kind requires
    always_comb begin
        need = '0;
        unique case (acc)
            ACC_STORE: need.w = 1'b1;
            ACC_FETCH: need.x = 1'b1;
            default:   need.r = 1'b1;
        endcase
    end

    assign missing = |(need & ~raw);

    always_comb begin
        cause = '0;
        if (guarded) begin
            cause.guard = 1'b1;
        end else if (missing) begin
            cause.prot  = 1'b1;
            cause.store = is_store;
        end
    end

    assign fault = cause.guard | cause.prot;

    always_comb begin
        grant = raw;
        if (!is_store) begin
            grant.w = 1'b0;
        end
    end

endmodule

// File: rtl/pgchk_rc.sv
module pgchk_rc #(
    parameter int unsigned PTE_W   = 64,
    parameter int unsigned REF_BIT = 8,
    parameter int unsigned CHG_BIT = 7
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_store,
    input  logic             fault,
    output logic [PTE_W-1:0] pte_new,
    output logic             wb
);

    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask          = '0;
        set_mask[REF_BIT] = 1'b1;
        set_mask[CHG_BIT] = is_store;
    end

    assign pte_new = fault ? pte : (pte | set_mask);
    assign wb      = !fault && ((pte & set_mask) != set_mask);

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int unsigned PTE_W     = 64,
    parameter int unsigned REF_BIT   = 8,
    parameter int unsigned CHG_BIT   = 7,
    parameter int unsigned ATT_LSB   = 4,
    parameter int unsigned PRIV_BIT  = 3,
    parameter int unsigned EAA_LSB   = 0,
    parameter logic [1:0]  ATT_NIIO  = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [1:0]       acc_i,
    input  logic [PTE_W-1:0] pte_i,
    input  logic             prob_i,
    input  logic             privctx_i,
    input  logic             part_i,
    input  logic [2:0]       amr_i,
    output logic             rsp_valid_o,
    output logic [2:0]       perm_o,
    output logic             fault_o,
    output logic [2:0]       cause_o,
    output logic [PTE_W-1:0] pte_o,
    output logic             wb_o
);

    localparam int unsigned ATT_MSB = ATT_LSB + 1;
    localparam int unsigned EAA_MSB = EAA_LSB + 2;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_e;

    state_e           state_q;
    state_e           state_d;
    acc_e             acc;
    perm_t            grant;
    logic             fault;
    cause_t           cause;
    logic [PTE_W-1:0] pte_new;
    logic             wb;

    assign acc = acc_e'(acc_i);

    pgchk_auth #(
        .ATT_NIIO (ATT_NIIO)
    ) u_auth (
        .acc     (acc),
        .att     (pte_i[ATT_MSB:ATT_LSB]),
        .priv    (pte_i[PRIV_BIT]),
        .eaa     (perm_t'(pte_i[EAA_MSB:EAA_LSB])),
        .prob    (prob_i),
        .privctx (privctx_i),
        .part    (part_i),
        .amr     (perm_t'(amr_i)),
        .grant   (grant),
        .fault   (fault),
        .cause   (cause)
    );

    pgchk_rc #(
        .PTE_W   (PTE_W),
        .REF_BIT (REF_BIT),
        .CHG_BIT (CHG_BIT)
    ) u_rc (
        .pte      (pte_i),
        .is_store (acc == ACC_STORE),
        .fault    (fault),
        .pte_new  (pte_new),
        .wb       (wb)
    );

    // next-state: IDLE_TO_RESP, RESP_TO_RESP, RESP_TO_IDLE, IDLE_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result registers, loaded on each accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_o  <= '0;
            fault_o <= 1'b0;
            cause_o <= '0;
            pte_o   <= '0;
            wb_o    <= 1'b0;
        end else if (req_i) begin
            perm_o  <= grant;
            fault_o <= fault;
            cause_o <= cause;
            pte_o   <= pte_new;
            wb_o    <= wb;
        end
    end

    assign rsp_valid_o = (state_q == ST_RESP);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o);                                            // R1
    AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!rsp_valid_o && $stable(pte_o) && $stable(perm_o)));   // R1
    AST_NONSTORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i != 2'd1) |=> !perm_o[1]);                          // R7
    AST_REF_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !fault_o) |-> pte_o[REF_BIT]);                     // R8
    AST_WB_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (wb_o == (!fault_o && (pte_o != $past(pte_i)))));        // R9
    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (cause_o[2] == (fault_o && $past(acc_i) == 2'd1)));      // R10
    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (fault_o == ($countones(cause_o[1:0]) == 1)));     // R6

endmodule

// File: tb/tb_pgchk_top.sv
module tb_pgchk_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  acc_i = '0;
    logic [63:0] pte_i = '0;
    logic        prob_i = 1'b0;
    logic        privctx_i = 1'b0;
    logic        part_i = 1'b0;
    logic [2:0]  amr_i = '0;
    logic        rsp_valid_o;
    logic [2:0]  perm_o;
    logic        fault_o;
    logic [2:0]  cause_o;
    logic [63:0] pte_o;
    logic        wb_o;

    int nchk = 0;
    int nfail = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pgchk_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_i(acc_i), .pte_i(pte_i),
        .prob_i(prob_i), .privctx_i(privctx_i), .part_i(part_i), .amr_i(amr_i),
        .rsp_valid_o(rsp_valid_o), .perm_o(perm_o), .fault_o(fault_o),
        .cause_o(cause_o), .pte_o(pte_o), .wb_o(wb_o)
    );

    // expected {perm[2:0], fault, cause[2:0], wb, pte[63:0]}
    function automatic logic [71:0] model(input logic [1:0] acc, input logic [63:0] pte,
                                          input logic prob, input logic pc,
                                          input logic part, input logic [2:0] amr);
        logic [2:0]  raw, need, perm, cause;
        logic        flt, wb;
        logic [63:0] np;
        if (!part && pte[3] && prob)     raw = 3'b000;           // R3
        else if (pc || pte[3] || part)   raw = pte[2:0];         // R4
        else                             raw = pte[2:0] & amr;   // R5
        need  = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
        cause = 3'b000;
        if (acc == 2'd2 && pte[5:4] == 2'b10) cause = 3'b001;    // R2
        else if ((need & ~raw) != 3'b000)     cause = (acc == 2'd1) ? 3'b110 : 3'b010; // R6 R10
        flt  = cause != 3'b000;
        perm = raw;
        if (acc != 2'd1) perm[1] = 1'b0;                         // R7
        np = pte;
        if (!flt) begin                                          // R8
            np[8] = 1'b1;
            if (acc == 2'd1) np[7] = 1'b1;
        end
        wb = np != pte;                                          // R9
        return {perm, flt, cause, wb, np};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [1:0] acc, input logic [63:0] pte,
                       input logic prob, input logic pc, input logic part,
                       input logic [2:0] amr, input bit hold);
        logic [71:0] exp;
        logic [71:0] got;
        exp = model(acc, pte, prob, pc, part, amr);
        @(negedge clk);
        req_i = 1'b1; acc_i = acc; pte_i = pte; prob_i = prob;
        privctx_i = pc; part_i = part; amr_i = amr;
        @(negedge clk);
        req_i = 1'b0;
        pte_i = ~pte;
        amr_i = ~amr;
        check("R1 valid", {71'd0, rsp_valid_o}, 72'd1);
        got = {perm_o, fault_o, cause_o, wb_o, pte_o};
        check(req, got, exp);
        if (hold) begin
            @(negedge clk);
            check("R1 hold", {rsp_valid_o, perm_o, fault_o, cause_o, wb_o, pte_o},
                  {1'b0, exp});
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        #1;
        check("R1 reset", {rsp_valid_o, perm_o, fault_o, cause_o, wb_o, pte_o}, 73'd0);
        #10 rst_n = 1'b1;

        // directed corner cases
        run("R2 guarded fetch", 2'd2, 64'h27, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1);
        run("R3 priv in problem state", 2'd0, 64'h0F, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0);
        run("R4 partition ignores mask", 2'd1, 64'h06, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0);
        run("R4 privctx ignores mask", 2'd0, 64'h04, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0);
        run("R5 mask strips read", 2'd0, 64'h07, 1'b0, 1'b0, 1'b0, 3'b011, 1'b0);
        run("R6 store to read-only", 2'd1, 64'h104, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1);
        run("R7 load on writable page", 2'd0, 64'h06, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R8 store sets ref and change", 2'd1, 64'h02, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R9 already referenced load", 2'd0, 64'h104, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R9 store change already set", 2'd1, 64'h182, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R9 store change missing", 2'd1, 64'h102, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R10 fetch no-exec", 2'd2, 64'h06, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);
        run("R2 reserved kind as load", 2'd3, 64'h24, 1'b0, 1'b1, 1'b0, 3'b111, 1'b0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [63:0] p;
            p = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) p[5:4] = 2'b10;
            run("R3 R4 R5 R6 R8 R9 random", 2'($urandom_range(0, 3)), p,
                1'($urandom()), 1'($urandom()), 1'($urandom()),
                3'($urandom()), (i % 16) == 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule